// File: doc/BRIEF.md
# SATA Port Interrupt Status Register

This block keeps the per-port interrupt status of a SATA host controller. Single-cycle event pulses from the frame receiver, the PIO data mover, the descriptor engine and the link layer set its status bits. The host clears them through a register write port. A small diagnostic register sits beside the status register. Its connect-change and unknown-frame bits are tied to two of the status bits, so those two status bits cannot be cleared directly. They clear only when the diagnostic bit behind them is cleared.

The host supplies a 32-bit interrupt enable mask. The block raises the port interrupt request whenever an enabled status bit is set. A read-select input picks which register the read data port shows. The status bit for the platform interlock switch only works when the capability input says the platform has such a switch.

Top module: `sataPortIntStatus`

## Requirements
- R1: After reset, every status bit, every diagnostic bit and `portIrq` is 0.
- R2: Status bit 0 (device-to-host register frame), bit 2 (DMA setup frame) and bit 3 (set-device-bits frame) each set on their copied pulse only when `frameIrqBit` is 1 in the same cycle. A copied pulse with `frameIrqBit` at 0 leaves the bit at 0.
- R3: Status bit 1 (PIO setup) sets only when `evtPioDataDone` pulses after, or in the same cycle as, a PIO copied pulse that carried `frameIrqBit`=1. A data-done pulse on its own, or one that follows a copied pulse without the interrupt bit, leaves bit 1 at 0.
- R4: Status bit 5 sets on `evtDescDone`. A write to the status register (`regWrSel`=0) with a 1 at bit 0, 1, 2, 3, 5 or 7 clears that bit. Written zeros change nothing.
- R5: Diagnostic bit 1 sets on `evtConnChange`. Status bit 6 always reads equal to diagnostic bit 1 and ignores status writes. Writing 1 to diagnostic bit 1 (`regWrSel`=1) clears both.
- R6: Diagnostic bit 0 sets at once on `evtUnkDetect`. Status bit 4 stays 0 until `evtUnkPosted` pulses, and status writes have no effect on it. Writing 1 to diagnostic bit 0 clears diagnostic bit 0 and status bit 4 on the same edge.
- R7: Status bit 7 sets on `evtInterlockToggle` while `capInterlock` is 1. While `capInterlock` is 0, bit 7 reads 0, does not raise `portIrq`, and is held cleared.
- R8: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: `portIrq` is the OR over all bits of the status read value ANDed with `intEnable`. It follows status changes with no added cycle.
- R10: `rdData` shows the status register when `regRdSel` is 0 and the diagnostic register when it is 1. Bits above 7 (status) and above 1 (diagnostic) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtD2hCopied | input | 1 | Device-to-host register frame copied to memory |
| evtPioCopied | input | 1 | PIO setup frame copied to memory |
| evtPioDataDone | input | 1 | Data for the last PIO setup frame has finished transferring |
| evtDmaCopied | input | 1 | DMA setup frame copied to memory |
| evtSdbCopied | input | 1 | Set-device-bits frame copied to memory |
| frameIrqBit | input | 1 | Interrupt bit of the frame that is being reported |
| evtUnkDetect | input | 1 | Unknown frame detected |
| evtUnkPosted | input | 1 | Unknown frame posted to memory |
| evtDescDone | input | 1 | Descriptor with interrupt bit finished its data |
| evtConnChange | input | 1 | Link connect state changed |
| evtInterlockToggle | input | 1 | Interlock switch opened or closed |
| capInterlock | input | 1 | Platform has an interlock switch |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | Write target: 0 status, 1 diagnostic |
| regWrData | input | 32 | Write data (ones clear) |
| regRdSel | input | 1 | Read source: 0 status, 1 diagnostic |
| intEnable | input | 32 | Interrupt enable mask |
| rdData | output | 32 | Read data |
| portIrq | output | 1 | Port interrupt request |

## Verification
A wrong stored bit shows on `rdData` and, if that bit is enabled, on `portIrq` at the very next falling edge after the event or write, since nothing lies between the registers and the outputs. A coupling fault between the diagnostic and status registers shows as a mismatch between status bits 4 or 6 and diagnostic bits 0 or 1. Such a fault appears only in a cycle where one side changes and the other should follow, so the bench reads both registers after every step of the unknown-frame and connect-change sequences. A stuck PIO pending flag shows only once a later data-done pulse arrives.

// File: rtl/sataPisPkg.sv
package sataPisPkg;
  localparam int STS_W  = 8;
  localparam int DIAG_W = 2;

  localparam int B_D2H  = 0;
  localparam int B_PIO  = 1;
  localparam int B_DMA  = 2;
  localparam int B_SDB  = 3;
  localparam int B_UNK  = 4;
  localparam int B_DESC = 5;
  localparam int B_CONN = 6;
  localparam int B_ILCK = 7;

  localparam int D_UNK  = 0;
  localparam int D_CONN = 1;

  // Bits that software clears by writing one to the status register
  localparam logic [STS_W-1:0] W1C_MASK = STS_W'((1 << B_D2H) | (1 << B_PIO) | (1 << B_DMA) |
                                                 (1 << B_SDB) | (1 << B_DESC) | (1 << B_ILCK));

  typedef struct packed {
    logic [STS_W-1:0]  setMask;
    logic [STS_W-1:0]  clrMask;
    logic [DIAG_W-1:0] diagSet;
    logic [DIAG_W-1:0] diagClr;
  } pisStrobe_t;
endpackage

// File: rtl/pisCtrl.sv
module pisCtrl
  import sataPisPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtD2hCopied,
  input  logic              evtPioCopied,
  input  logic              evtPioDataDone,
  input  logic              evtDmaCopied,
  input  logic              evtSdbCopied,
  input  logic              frameIrqBit,
  input  logic              evtUnkDetect,
  input  logic              evtUnkPosted,
  input  logic              evtDescDone,
  input  logic              evtConnChange,
  input  logic              evtInterlockToggle,
  input  logic              capInterlock,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  output pisStrobe_t        strobes
);
  localparam int N_FRAME = 3;

  logic               pioPending;
  logic               pioArm;
  logic [N_FRAME-1:0] frameEvt;
  logic [STS_W-1:0]   setNext;

  // PIO setup that carried the interrupt bit waits for its data
  assign pioArm = evtPioCopied && frameIrqBit;

  always_ff @(posedge clk) begin
    if (!rstN)               pioPending <= 1'b0;
    else if (evtPioDataDone) pioPending <= 1'b0;
    else if (pioArm)         pioPending <= 1'b1;
  end

  assign frameEvt = {evtSdbCopied, evtDmaCopied, evtD2hCopied};

  always_comb begin
    setNext = '0;
    for (int k = 0; k < N_FRAME; k++) begin
      case (k)
        0:       setNext[B_D2H] = frameEvt[k] && frameIrqBit;
        1:       setNext[B_DMA] = frameEvt[k] && frameIrqBit;
        default: setNext[B_SDB] = frameEvt[k] && frameIrqBit;
      endcase
    end
    setNext[B_PIO]  = evtPioDataDone && (pioPending || pioArm);
    setNext[B_DESC] = evtDescDone;
    setNext[B_UNK]  = evtUnkPosted;
    setNext[B_ILCK] = evtInterlockToggle && capInterlock;
  end

  always_comb begin
    strobes = '0;
    strobes.setMask = setNext;
    strobes.diagSet[D_UNK]  = evtUnkDetect;
    strobes.diagSet[D_CONN] = evtConnChange;
    if (regWrEn && !regWrSel) strobes.clrMask = regWrData[STS_W-1:0] & W1C_MASK;
    if (regWrEn && regWrSel)  strobes.diagClr = regWrData[DIAG_W-1:0];
  end

  AST_PIO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setMask[B_PIO] |-> evtPioDataDone); // R3
  AST_CLR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.clrMask || |strobes.diagClr) |-> regWrEn); // R4
endmodule

// File: rtl/pisData.sv
module pisData
  import sataPisPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pisStrobe_t        strobes,
  input  logic              capInterlock,
  input  logic              regRdSel,
  input  logic [DATA_W-1:0] intEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              portIrq
);
  localparam int PAD_S = DATA_W - STS_W;
  localparam int PAD_D = DATA_W - DIAG_W;

  logic [STS_W-1:0]  stsReg, stsNext, stsVis;
  logic [DIAG_W-1:0] diagReg, diagNext;

  // Diagnostic bits: set beats a write-one-to-clear
  for (genvar j = 0; j < DIAG_W; j++) begin : gDiag
    assign diagNext[j] = strobes.diagSet[j] ? 1'b1 :
                         strobes.diagClr[j] ? 1'b0 : diagReg[j];
  end

  always_comb begin
    stsNext = stsReg;
    for (int i = 0; i < STS_W; i++) begin
      if (i == B_CONN) begin
        stsNext[i] = 1'b0;  // storage unused, read from diagnostic
      end else if (i == B_UNK) begin
        if (strobes.setMask[i])                                           stsNext[i] = 1'b1;
        else if (strobes.diagClr[D_UNK] && !strobes.diagSet[D_UNK])      stsNext[i] = 1'b0;
      end else begin
        if (strobes.setMask[i])      stsNext[i] = 1'b1;
        else if (strobes.clrMask[i]) stsNext[i] = 1'b0;
      end
    end
    if (!capInterlock) stsNext[B_ILCK] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsReg  <= '0;
      diagReg <= '0;
    end else begin
      stsReg  <= stsNext;
      diagReg <= diagNext;
    end
  end

  always_comb begin
    stsVis         = stsReg;
    stsVis[B_CONN] = diagReg[D_CONN];
    stsVis[B_ILCK] = stsReg[B_ILCK] && capInterlock;
  end

  assign rdData  = regRdSel ? {{PAD_D{1'b0}}, diagReg} : {{PAD_S{1'b0}}, stsVis};
  assign portIrq = |(stsVis & intEnable[STS_W-1:0]);

  AST_UNK_FOLLOWS_DIAG: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(diagReg[D_UNK]) && !$past(strobes.setMask[B_UNK])) |-> !stsReg[B_UNK]); // R6
  AST_UNK_NEEDS_POST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsReg[B_UNK]) |-> $past(strobes.setMask[B_UNK])); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(strobes.setMask) & W1C_MASK & ~STS_W'(1 << B_ILCK)) & ~stsReg) == '0)); // R8
  AST_ILCK_CAP: assert property (@(posedge clk) disable iff (!rstN)
    !capInterlock |=> !stsReg[B_ILCK]); // R7
endmodule

// File: rtl/sataPortIntStatus.sv
module sataPortIntStatus
  import sataPisPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtD2hCopied,
  input  logic              evtPioCopied,
  input  logic              evtPioDataDone,
  input  logic              evtDmaCopied,
  input  logic              evtSdbCopied,
  input  logic              frameIrqBit,
  input  logic              evtUnkDetect,
  input  logic              evtUnkPosted,
  input  logic              evtDescDone,
  input  logic              evtConnChange,
  input  logic              evtInterlockToggle,
  input  logic              capInterlock,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdSel,
  input  logic [DATA_W-1:0] intEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              portIrq
);
  pisStrobe_t strobes;

  pisCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .evtD2hCopied(evtD2hCopied), .evtPioCopied(evtPioCopied),
    .evtPioDataDone(evtPioDataDone), .evtDmaCopied(evtDmaCopied),
    .evtSdbCopied(evtSdbCopied), .frameIrqBit(frameIrqBit),
    .evtUnkDetect(evtUnkDetect), .evtUnkPosted(evtUnkPosted),
    .evtDescDone(evtDescDone), .evtConnChange(evtConnChange),
    .evtInterlockToggle(evtInterlockToggle), .capInterlock(capInterlock),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .strobes(strobes)
  );

  pisData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .capInterlock(capInterlock),
    .regRdSel(regRdSel), .intEnable(intEnable), .rdData(rdData), .portIrq(portIrq)
  );
endmodule

// File: tb/sataPortIntStatus_tb.sv
module sataPortIntStatus_tb;
  logic clk = 1'b0;
  logic rstN;
  logic evtD2hCopied, evtPioCopied, evtPioDataDone, evtDmaCopied, evtSdbCopied, frameIrqBit;
  logic evtUnkDetect, evtUnkPosted, evtDescDone, evtConnChange, evtInterlockToggle, capInterlock;
  logic regWrEn, regWrSel, regRdSel;
  logic [31:0] regWrData, intEnable, rdData;
  logic portIrq;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  sataPortIntStatus u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {evtD2hCopied, evtPioCopied, evtPioDataDone, evtDmaCopied, evtSdbCopied, frameIrqBit} = '0;
    {evtUnkDetect, evtUnkPosted, evtDescDone, evtConnChange, evtInterlockToggle} = '0;
    regWrEn = 0; regWrSel = 0; regWrData = '0;
  endtask

  // inputs already placed after a falling edge; let one rising edge pass
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wrReg(input logic sel, input logic [31:0] d);
    regWrEn = 1; regWrSel = sel; regWrData = d;
    step();
  endtask

  function automatic logic [31:0] rd(input logic sel);
    return 32'(0);
  endfunction

  task automatic readSts(output logic [31:0] v);
    regRdSel = 0; #1; v = rdData;
  endtask

  task automatic readDiag(output logic [31:0] v);
    regRdSel = 1; #1; v = rdData; regRdSel = 0;
  endtask

  task automatic expectRegs(input string req, input logic [31:0] s, input logic [31:0] d);
    logic [31:0] v;
    readSts(v);  check(req, v, s);
    readDiag(v); check(req, v, d);
  endtask

  // sets every write-one-to-clear bit (0,1,2,3,5,7)
  task automatic setAllW1c();
    frameIrqBit = 1; evtD2hCopied = 1; evtDmaCopied = 1; evtSdbCopied = 1;
    evtPioCopied = 1; evtPioDataDone = 1; evtDescDone = 1; evtInterlockToggle = 1;
    step();
  endtask

  function automatic logic [7:0] expand6(input logic [5:0] p);
    return {p[5], 1'b0, p[4], 1'b0, p[3:0]};
  endfunction

  initial begin
    #(20 * 20000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(); regRdSel = 0; intEnable = '0; capInterlock = 1; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    intEnable = 32'hFFFF_FFFF;
    expectRegs("R1", 0, 0);
    #1 check("R1 irq", {31'd0, portIrq}, 0);

    // R2 frame bits, with and without interrupt bit
    evtD2hCopied = 1; evtDmaCopied = 1; evtSdbCopied = 1; frameIrqBit = 0; step();
    expectRegs("R2 no ibit", 0, 0);
    evtD2hCopied = 1; frameIrqBit = 1; step(); expectRegs("R2 d2h", 32'h01, 0);
    evtDmaCopied = 1; frameIrqBit = 1; step(); expectRegs("R2 dma", 32'h05, 0);
    evtSdbCopied = 1; frameIrqBit = 1; step(); expectRegs("R2 sdb", 32'h0D, 0);
    // R4 clear one bit at a time, zeros do nothing
    wrReg(0, 32'h0); expectRegs("R4 zero write", 32'h0D, 0);
    wrReg(0, 32'h4); expectRegs("R4 clr dma", 32'h09, 0);
    wrReg(0, 32'hFFFF_FFFF); expectRegs("R4 clr all", 0, 0);

    // R3 PIO ordering
    evtPioCopied = 1; frameIrqBit = 1; step(); expectRegs("R3 copied only", 0, 0);
    step(); step();
    evtPioDataDone = 1; step(); expectRegs("R3 data after", 32'h02, 0);
    wrReg(0, 32'h2); expectRegs("R4 clr pio", 0, 0);
    evtPioDataDone = 1; step(); expectRegs("R3 data alone", 0, 0);
    evtPioCopied = 1; frameIrqBit = 0; step();
    evtPioDataDone = 1; step(); expectRegs("R3 no ibit", 0, 0);
    evtPioCopied = 1; frameIrqBit = 1; evtPioDataDone = 1; step();
    expectRegs("R3 same cycle", 32'h02, 0);
    wrReg(0, 32'h2);

    // R4 descriptor
    evtDescDone = 1; step(); expectRegs("R4 desc", 32'h20, 0);
    wrReg(0, 32'h20); expectRegs("R4 desc clr", 0, 0);

    // R6 unknown frame: status waits for posting
    evtUnkDetect = 1; step(); expectRegs("R6 detect only", 0, 32'h1);
    step(); expectRegs("R6 still waiting", 0, 32'h1);
    wrReg(0, 32'hFF); expectRegs("R6 status write ignored", 0, 32'h1);
    evtUnkPosted = 1; step(); expectRegs("R6 posted", 32'h10, 32'h1);
    wrReg(0, 32'h10); expectRegs("R6 ro", 32'h10, 32'h1);
    wrReg(1, 32'h1); expectRegs("R6 diag clr", 0, 0);

    // R5 connect change mirror
    evtConnChange = 1; step(); expectRegs("R5 set", 32'h40, 32'h2);
    wrReg(0, 32'h40); expectRegs("R5 status write ignored", 32'h40, 32'h2);
    intEnable = 32'h40; #1 check("R9 conn irq", {31'd0, portIrq}, 1);
    wrReg(1, 32'h2); expectRegs("R5 diag clr", 0, 0);

    // R7 interlock gating
    evtInterlockToggle = 1; step(); expectRegs("R7 set", 32'h80, 0);
    intEnable = 32'hFFFF_FFFF;
    capInterlock = 0; #1;
    expectRegs("R7 gated", 0, 0);
    check("R7 irq", {31'd0, portIrq}, 0);
    step(); capInterlock = 1; #1; expectRegs("R7 held clear", 0, 0);
    capInterlock = 0; evtInterlockToggle = 1; step(); expectRegs("R7 no cap", 0, 0);
    capInterlock = 1;

    // R8 set wins over clear
    evtD2hCopied = 1; frameIrqBit = 1; regWrEn = 1; regWrSel = 0; regWrData = 32'h1; step();
    expectRegs("R8 frame", 32'h01, 0);
    evtUnkDetect = 1; evtUnkPosted = 1; step();
    evtUnkPosted = 1; regWrEn = 1; regWrSel = 1; regWrData = 32'h1; step();
    expectRegs("R8 unk", 32'h11, 0);
    wrReg(0, 32'hFF); wrReg(1, 32'h3); expectRegs("R8 cleanup", 0, 0);

    // R9/R10 sweep of write-one-to-clear patterns against each enable bit
    for (int p = 0; p < 64; p++) begin
      logic [7:0] e;
      e = expand6(6'(p));
      setAllW1c();
      wrReg(0, {24'hFF_FFFF, ~e});
      expectRegs("R10 pattern", {24'd0, e}, 0);
      for (int b = 0; b < 8; b++) begin
        intEnable = 32'h1 << b; #1;
        check("R9 single enable", {31'd0, portIrq}, {31'd0, e[b]});
      end
      intEnable = 32'hFFFF_FF00; #1;
      check("R9 upper enable", {31'd0, portIrq}, 0);
      wrReg(0, 32'hFF);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule